// File: doc/BRIEF.md
# SPI Master with Continuous Transfer

This block is a memory-mapped serial peripheral master that talks to exactly one slave in SPI mode 3. Software reaches it through a 32-bit word-access register port: a control word, a status word, a select word, a transmit push address and a receive pop address. Behind the port sit optional transmit and receive queues, a clock divider, a shift engine and the glue between them.

Software raises the select bit, which drives the slave-select pin low, and pushes elements. While the engine is enabled and select is held, elements leave back to back, with no idle clock between them, for as long as the transmit queue holds data. The engine goes quiet when the queue empties. A new transaction is framed by software dropping and raising select again.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset the status word reads 0x05 (receive empty, transmit empty), the select word reads 0, `spi_ss_n` is 1 and `spi_sck` is 1.
- R2: Bit 0 of the select word (byte address 0x08) drives `spi_ss_n` low when set. Bits 31:1 are ignored and read back as 0.
- R3: The serial clock idles high. `spi_mosi` changes only as `spi_sck` falls, and `spi_miso` is captured as `spi_sck` rises.
- R4: Each element is XFER_W bits and is shifted most significant bit first. Received elements are read at byte address 0x10, zero-extended. Transmit elements are pushed at byte address 0x0C from the low XFER_W bits.
- R5: With n elements queued, the engine shifts them with no gap: from the first falling clock edge to the last rising edge spans (2·XFER_W·n−1)·SCK_HALF cycles. Shifting stops when the queue is empty.
- R6: Shifting starts only while control bit 0 (enable) and the select bit are both set. Otherwise the clock stays high and nothing is taken from the transmit queue.
- R7: Every low half-period of `spi_sck` lasts SCK_HALF clock cycles.
- R8: With HAS_FIFO=1 each queue holds 16 elements. The status word (byte address 0x04) gives bit0 receive empty, bit1 receive full, bit2 transmit empty, bit3 transmit full and bit4 overrun.
- R9: A push to a full transmit queue is dropped.
- R10: An element received while the receive queue is full is dropped and sets the overrun bit. The overrun bit stays set until the receive queue is reset.
- R11: A write whose byte enables are not all ones has no effect.
- R12: Writing control (byte address 0x00) with bit 1 set empties the transmit queue, and with bit 2 set empties the receive queue and clears overrun. Neither bit is stored.
- R13: A received element enters the receive queue on the rising clock edge of its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x10) |
| reg_addr | input | 5 | Byte address, bits 1:0 ignored |
| reg_be | input | 4 | Byte enables; writes need all four |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| spi_sck | output | 1 | Serial clock, idle high |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_ss_n | output | 1 | Active-low slave select |

## Verification
The bench builds the block with XFER_W=8, HAS_FIFO=1 and SCK_HALF=2. The short half-period keeps a full 16-element burst to about 512 cycles, so the bench can fill both queues, force an overrun and time a three-element chain edge by edge. The 8-bit width lets the slave model check every bit pattern in the table quickly, including all zeros, all ones and alternating bits.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int REG_CTRL = 0;
  localparam int REG_STAT = 1;
  localparam int REG_SEL  = 2;
  localparam int REG_TX   = 3;
  localparam int REG_RX   = 4;

  localparam int CTRL_EN     = 0;
  localparam int CTRL_TX_CLR = 1;
  localparam int CTRL_RX_CLR = 2;

  function automatic logic [31:0] status_pack(input logic rx_e, input logic rx_f,
                                              input logic tx_e, input logic tx_f,
                                              input logic ovr);
    status_pack = {27'd0, ovr, tx_f, tx_e, rx_f, rx_e};
  endfunction

  function automatic int chain_span(input int w, input int n, input int half);
    chain_span = (2 * w * n - 1) * half;
  endfunction
endpackage

// File: rtl/spi_xfer_fifo.sv
module spi_xfer_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  generate
    if (DEPTH == 1) begin : g_single
      logic [W-1:0] q;
      logic         vld;
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          vld <= 1'b0;
          q   <= '0;
        end else if (push && !vld) begin
          vld <= 1'b1;
          q   <= din;
        end else if (pop && vld) begin
          vld <= 1'b0;
        end
      end
      assign dout  = q;
      assign empty = !vld;
      assign full  = vld;
    end else begin : g_ring
      localparam int AW = $clog2(DEPTH);
      logic [W-1:0]  mem [DEPTH];
      logic [AW-1:0] wp, rp;
      logic [AW:0]   cnt;
      logic          do_push, do_pop;
      assign empty   = (cnt == '0);
      assign full    = (cnt == (AW+1)'(DEPTH));
      assign do_push = push && !full;
      assign do_pop  = pop && !empty;
      assign dout    = mem[rp];
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          wp  <= '0;
          rp  <= '0;
          cnt <= '0;
        end else begin
          if (do_push) wp <= wp + 1'b1;
          if (do_pop)  rp <= rp + 1'b1;
          if (do_push && !do_pop)      cnt <= cnt + 1'b1;
          else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
      end
      always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
      end
    end
  endgenerate
endmodule

// File: rtl/spi_xfer_baud.sv
module spi_xfer_baud #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || cnt == LAST) cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine #(
  parameter int W    = 8,
  parameter int HALF = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_ok,
  input  logic         tx_avail,
  input  logic [W-1:0] tx_data,
  input  logic         miso,
  output logic         tx_pop,
  output logic         rx_push,
  output logic [W-1:0] rx_data,
  output logic         sck,
  output logic         mosi,
  output logic         busy,
  output logic         ev_rise,
  output logic         ev_fall
);
  localparam int BW = $clog2(W);
  logic [W-1:0]  sh, rsh, rx_next;
  logic [BW-1:0] bcnt;
  logic          tick, go, last_bit, start_idle, chain, load;

  spi_xfer_baud #(.HALF(HALF)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  assign go         = run_ok && tx_avail;
  assign last_bit   = (bcnt == '0);
  assign start_idle = !busy && go;
  assign chain      = busy && tick && sck && last_bit && go;
  assign load       = start_idle || chain;
  assign tx_pop     = load;
  assign rx_next    = {rsh[W-2:0], miso};
  assign ev_rise    = busy && tick && !sck;
  assign ev_fall    = load || (busy && tick && sck && !last_bit);
  assign rx_push    = ev_rise && last_bit;
  assign rx_data    = rx_next;
  assign mosi       = sh[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sck  <= 1'b1;
      sh   <= '0;
      rsh  <= '0;
      bcnt <= '0;
    end else if (load) begin
      busy <= 1'b1;
      sck  <= 1'b0;
      sh   <= tx_data;
      bcnt <= BW'(W - 1);
    end else if (busy && tick) begin
      if (!sck) begin
        sck <= 1'b1;
        rsh <= rx_next;
      end else if (!last_bit) begin
        sck  <= 1'b0;
        sh   <= {sh[W-2:0], 1'b0};
        bcnt <= bcnt - 1'b1;
      end else begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
  parameter int XFER_W   = 8,
  parameter int HAS_FIFO = 1,
  parameter int SCK_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [4:0]  reg_addr,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_ss_n
);
  import spi_xfer_pkg::*;
  localparam int DEPTH = (HAS_FIFO != 0) ? 16 : 1;

  logic [2:0]        idx;
  logic              wr_ok, tx_push, tx_clr, rx_clr, rx_pop;
  logic              en_q, sel_q, ovr_q;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [XFER_W-1:0] tx_head, rx_head, eng_rx_data;
  logic              eng_tx_pop, eng_rx_push, eng_busy, eng_rise, eng_fall;

  assign idx     = reg_addr[4:2];
  assign wr_ok   = reg_wr && (reg_be == 4'hF);
  assign tx_push = wr_ok && idx == 3'(REG_TX);
  assign tx_clr  = wr_ok && idx == 3'(REG_CTRL) && reg_wdata[CTRL_TX_CLR];
  assign rx_clr  = wr_ok && idx == 3'(REG_CTRL) && reg_wdata[CTRL_RX_CLR];
  assign rx_pop  = reg_rd && idx == 3'(REG_RX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (wr_ok && idx == 3'(REG_CTRL)) en_q  <= reg_wdata[CTRL_EN];
      if (wr_ok && idx == 3'(REG_SEL))  sel_q <= reg_wdata[0];
      if (rx_clr)                       ovr_q <= 1'b0;
      else if (eng_rx_push && rx_full)  ovr_q <= 1'b1;
    end
  end

  spi_xfer_fifo #(.W(XFER_W), .DEPTH(DEPTH)) u_txq (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tx_clr),
    .push (tx_push),
    .din  (reg_wdata[XFER_W-1:0]),
    .pop  (eng_tx_pop),
    .dout (tx_head),
    .empty(tx_empty),
    .full (tx_full)
  );

  spi_xfer_fifo #(.W(XFER_W), .DEPTH(DEPTH)) u_rxq (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (rx_clr),
    .push (eng_rx_push && !rx_full),
    .din  (eng_rx_data),
    .pop  (rx_pop),
    .dout (rx_head),
    .empty(rx_empty),
    .full (rx_full)
  );

  spi_xfer_engine #(.W(XFER_W), .HALF(SCK_HALF)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_ok  (en_q && sel_q),
    .tx_avail(!tx_empty),
    .tx_data (tx_head),
    .miso    (spi_miso),
    .tx_pop  (eng_tx_pop),
    .rx_push (eng_rx_push),
    .rx_data (eng_rx_data),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .busy    (eng_busy),
    .ev_rise (eng_rise),
    .ev_fall (eng_fall)
  );

  assign spi_ss_n = !sel_q;

  always_comb begin
    reg_rdata = '0;
    case (idx)
      3'(REG_CTRL): reg_rdata = {31'd0, en_q};
      3'(REG_STAT): reg_rdata = status_pack(rx_empty, rx_full, tx_empty, tx_full, ovr_q);
      3'(REG_SEL):  reg_rdata = {31'd0, sel_q};
      3'(REG_RX):   reg_rdata = rx_empty ? 32'd0 : 32'(rx_head);
      default:      reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk #(
  parameter int SCK_HALF = 4
) (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic mosi,
  input logic busy,
  input logic rx_push,
  input logic en,
  input logic ovr,
  input logic rx_clr,
  input logic tx_full,
  input logic tx_empty
);
  logic [15:0] lowcnt;
  always_ff @(posedge clk) begin
    if (!rst_n || sck) lowcnt <= '0;
    else               lowcnt <= lowcnt + 1'b1;
  end

  a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck);
  a_r3_mosi_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  a_r7_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && !$past(sck)) |-> (lowcnt == 16'(SCK_HALF)));
  a_r13_push_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> $rose(sck));
  a_r6_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !rx_clr) |=> ovr);
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));
endmodule

bind spi_xfer_master spi_xfer_master_chk #(.SCK_HALF(SCK_HALF)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sck     (spi_sck),
  .mosi    (spi_mosi),
  .busy    (eng_busy),
  .rx_push (eng_rx_push),
  .en      (en_q),
  .ovr     (ovr_q),
  .rx_clr  (rx_clr),
  .tx_full (tx_full),
  .tx_empty(tx_empty)
);

// File: tb/spi_xfer_master_test.sv
`timescale 1ns/1ps
module spi_xfer_master_test;
  localparam int W = 8;
  localparam int HALF = 2;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SEL = 5'h08,
                         A_TX = 5'h0C, A_RX = 5'h10;
  localparam logic [15:0] TAB [6] = '{16'h00_3C, 16'hFF_00, 16'h81_FF,
                                      16'h5A_A5, 16'hC3_81, 16'h7E_18};

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [4:0] reg_addr = 0;
  logic [3:0] reg_be = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic spi_sck, spi_mosi, spi_ss_n;
  logic spi_miso = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = !clk;

  spi_xfer_master #(.XFER_W(W), .HAS_FIFO(1), .SCK_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_ss_n(spi_ss_n));

  // slave model, mode 3
  logic [7:0] sl_rep [64];
  logic [7:0] sl_cap [64];
  logic [7:0] sl_sh = 0;
  int sl_n = 0, sl_bp = 0, nfall = 0;
  time t_fall [1024];
  time t_rise_last = 0;

  always @(negedge spi_sck) begin
    if (nfall < 1024) t_fall[nfall] = $time;
    nfall = nfall + 1;
    if (spi_ss_n === 1'b0) spi_miso = sl_rep[sl_n][7 - sl_bp];
  end

  always @(posedge spi_sck) begin
    t_rise_last = $time;
    if (spi_ss_n === 1'b0) begin
      sl_sh = {sl_sh[6:0], spi_mosi};
      if (sl_bp == 7) begin
        sl_cap[sl_n] = sl_sh;
        sl_n = sl_n + 1;
        sl_bp = 0;
      end else sl_bp = sl_bp + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 0; reg_be = 0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wait_stat(input int bitn, input logic val, input string req);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      bus_rd(A_STAT, s);
      if (s[bitn] == val) return;
    end
    chk(req, 32'(!val), 32'(val));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) sl_rep[i] = 8'(i * 29 + 7);
    for (int i = 0; i < 6; i++) sl_rep[i] = TAB[i][7:0];
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n0, base;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    bus_rd(A_STAT, d); chk("R1 status", d, 32'h05);
    bus_rd(A_SEL, d);  chk("R1 select", d, 0);
    chk("R1 ss_n", 32'(spi_ss_n), 1);
    chk("R1 sck", 32'(spi_sck), 1);

    // R11 partial writes ignored
    bus_wr(A_SEL, 32'h1, 4'h1);
    chk("R11 sel partial", 32'(spi_ss_n), 1);
    bus_wr(A_TX, 32'h55, 4'h3);
    bus_rd(A_STAT, d); chk("R11 tx partial", d[2], 1);

    // R2 select bits
    bus_wr(A_SEL, 32'hFFFF_FFFE, 4'hF);
    chk("R2 upper bits", 32'(spi_ss_n), 1);
    bus_rd(A_SEL, d); chk("R2 readback zero", d, 0);
    bus_wr(A_SEL, 32'hFFFF_FFFF, 4'hF);
    chk("R2 assert", 32'(spi_ss_n), 0);
    bus_rd(A_SEL, d); chk("R2 readback one", d, 1);

    // R6 engine disabled: no clock, no pop; R12 tx reset
    n0 = nfall;
    bus_wr(A_TX, 32'h3C, 4'hF);
    repeat (40) @(posedge clk);
    chk("R6 no sck edge", 32'(nfall - n0), 0);
    bus_rd(A_STAT, d); chk("R6 tx kept", d[2], 0);
    bus_wr(A_CTRL, 32'h2, 4'hF);
    bus_rd(A_STAT, d); chk("R12 tx cleared", d[2], 1);
    bus_rd(A_CTRL, d); chk("R12 not stored", d, 0);

    // table: R3 R4 R13
    bus_wr(A_CTRL, 32'h1, 4'hF);
    for (int i = 0; i < 6; i++) begin
      bus_wr(A_TX, 32'hABCD_0000 | 32'(TAB[i][15:8]), 4'hF);
      wait_stat(0, 1'b0, "R13 rx arrival");
      bus_rd(A_RX, d);
      chk("R3 R13 rx element", d, 32'(TAB[i][7:0]));
      chk("R4 mosi msb first", 32'(sl_cap[i]), 32'(TAB[i][15:8]));
    end

    // R5 continuous chain, R7 period
    bus_wr(A_CTRL, 32'h0, 4'hF);
    base = sl_n;
    for (int i = 0; i < 3; i++) bus_wr(A_TX, 32'(8'h20 + i), 4'hF);
    n0 = nfall;
    bus_wr(A_CTRL, 32'h1, 4'hF);
    wait_stat(2, 1'b1, "R5 tx drained");
    repeat (4 * HALF * W) @(posedge clk);
    chk("R5 fall count", 32'(nfall - n0), 32'(3 * W));
    chk("R5 R7 chain span", 32'((t_rise_last - t_fall[n0]) / 5),
        32'((2 * W * 3 - 1) * HALF));
    n0 = nfall;
    repeat (50) @(posedge clk);
    chk("R5 stops when empty", 32'(nfall - n0), 0);
    for (int i = 0; i < 3; i++) begin
      bus_rd(A_RX, d);
      chk("R5 chain rx", d, 32'(sl_rep[base + i]));
      chk("R5 chain mosi", 32'(sl_cap[base + i]), 32'(8'h20 + i));
    end

    // R8 R9 R10 queues full and overrun
    bus_wr(A_CTRL, 32'h0, 4'hF);
    base = sl_n;
    for (int i = 0; i < 17; i++) bus_wr(A_TX, 32'(8'h40 + i), 4'hF);
    bus_rd(A_STAT, d); chk("R8 R9 tx full", d[3:2], 2'b10);
    bus_wr(A_CTRL, 32'h1, 4'hF);
    wait_stat(2, 1'b1, "R8 burst drained");
    repeat (4 * HALF * W) @(posedge clk);
    bus_rd(A_STAT, d); chk("R8 rx full no overrun", d[4:0], 5'b00110);
    bus_wr(A_TX, 32'h99, 4'hF);
    wait_stat(4, 1'b1, "R10 overrun set");
    chk("R9 17th dropped", 32'(sl_n - base), 17);
    chk("R9 extra element", 32'(sl_cap[base + 16]), 32'h99);
    for (int i = 0; i < 16; i++) begin
      bus_rd(A_RX, d);
      chk("R10 kept element", d, 32'(sl_rep[base + i]));
      chk("R9 sent element", 32'(sl_cap[base + i]), 32'(8'h40 + i));
    end
    bus_rd(A_STAT, d); chk("R10 rx empty overrun held", d[4:0], 5'b10101);
    bus_wr(A_CTRL, 32'h5, 4'hF);
    bus_rd(A_STAT, d); chk("R10 R12 overrun cleared", d[4:0], 5'b00101);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule